// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Flag Generator

This block sits beside a dual-clock FIFO and produces its two early-warning flags, almost-empty and almost-full. Both are active low. It follows the fill level by counting accepted write strobes on the write clock and accepted read strobes on the read clock. Each pointer crosses to the other clock domain through a Gray-coded two-stage synchronizer. Each flag is compared against its own offset register. The empty offset is a count of stored words. The full offset is a count of free slots.

Three pins are sampled while master reset is held: the load pin and a two-bit select. Together they pick one of eight default offset values, and both offsets take that value. The load pin level on its own also fixes how the offsets may be rewritten later: one whole word per strobe (parallel) or one bit per strobe (serial). A fourth pin sampled during reset chooses the flag timing. In synchronous timing each flag is owned by a single clock. In asynchronous timing each flag is set by the clock whose strobes move the level towards the threshold, and cleared by the other clock.

After reset, holding the load pin low turns the write and read strobes into offset-register accesses instead of data transfers. Reading the offsets back is always parallel, whichever write method was latched.

Top module: `prog_almost_flags`

## Requirements
- R1: While `rst` is high, both offsets load the default 2*i+1, capped at DEPTH-1, where i = {load_n, fsel[1], fsel[0]}. load_n high at reset selects parallel offset writes and low selects serial. sync_mode high at reset selects synchronous flag timing and low selects asynchronous.
- R2: Right after reset the FIFO counts as empty: almost_empty_n = 0, almost_full_n = 1, off_out = 0.
- R3: Once the pointers have settled, almost_empty_n is 0 exactly when the fill count is less than or equal to the empty offset.
- R4: Once the pointers have settled, almost_full_n is 0 exactly when DEPTH minus the fill count is less than or equal to the full offset.
- R5: A write or read strobe moves the fill count only when load_n is high. A write when the count is DEPTH is ignored, and so is a read when the count is 0.
- R6: In parallel mode, write strobes taken with load_n low store off_in into the empty offset, then the full offset, alternating. Any clock with load_n high restarts the sequence at the empty offset.
- R7: In serial mode, each write strobe with load_n low stores off_in[0], least significant bit first: first the OW bits of the empty offset, then the OW bits of the full offset. The other bits of off_in are ignored.
- R8: A read strobe with load_n low places the empty offset on off_out at that read-clock edge, the next one the full offset, alternating. Any clock with load_n high restarts at the empty offset. This works the same in both write methods.
- R9: In synchronous timing, almost_empty_n changes only on read-clock edges and almost_full_n only on write-clock edges. A write that lifts the count above the empty offset releases almost_empty_n only after the write pointer has crossed the synchronizer, so not at the first edge after the write.
- R10: In asynchronous timing, a write that lifts the count above the empty offset releases almost_empty_n at that same write edge. A read that brings the count to the empty offset or below asserts it at that read edge. Almost-full works the same way with the roles of the two clocks swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high master reset, sampled on both clocks |
| wr_en | input | 1 | Write strobe: a data write, or an offset write when load_n is low |
| rd_en | input | 1 | Read strobe: a data read, or an offset readback when load_n is low |
| load_n | input | 1 | Reset: default select and method. After reset: low selects offset access |
| fsel | input | 2 | Default offset select, sampled during reset |
| sync_mode | input | 1 | Flag timing select, sampled during reset |
| off_in | input | OW | Offset write data (serial mode uses bit 0 only) |
| almost_empty_n | output | 1 | Almost-empty flag, active low |
| almost_full_n | output | 1 | Almost-full flag, active low |
| off_out | output | OW | Offset readback bus |

## Verification
The bench builds the block with DEPTH = 16, which gives 4-bit offsets, 5-bit pointers and eight serial strobes per full offset load. A depth this small lets every fill level from empty to full be visited and checked with each offset in use. That includes the threshold crossings, the ignored write at full and the ignored read at empty. Both clock ports are driven from one clock, so the synchronizer delay is a fixed number of edges. This lets the bench tell synchronous timing from asynchronous timing by sampling one edge after a single strobe.

// File: rtl/paf_pkg.sv
`timescale 1ns/1ps
package paf_pkg;

  // Default offset for select index idx = {load_n, fsel}
  function automatic int unsigned dflt_offset(input int unsigned idx, input int unsigned depth);
    int unsigned v;
    v = 2 * idx + 1;
    return (v > depth - 1) ? depth - 1 : v;
  endfunction

endpackage

// File: rtl/paf_level.sv
`timescale 1ns/1ps
module paf_level #(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH) + 1
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          load_n,
  output logic          wr_fire,
  output logic          rd_fire,
  output logic [PW-1:0] count_w,
  output logic [PW-1:0] count_r
);

  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] wg_s1, wg_s2, rg_s1, rg_s2;
  logic [PW-1:0] wbin_nx, rbin_nx;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_comb begin
    count_w = wbin - g2b(rg_s2);
    count_r = g2b(wg_s2) - rbin;
    wr_fire = wr_en & load_n & (count_w != FULL_CNT);
    rd_fire = rd_en & load_n & (count_r != '0);
    wbin_nx = wbin + 1'b1;
    rbin_nx = rbin + 1'b1;
  end

  always_ff @(posedge wclk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wr_fire) begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
    end
  end

  always_ff @(posedge rclk) begin
    if (rst) begin
      rbin  <= '0;
      rgray <= '0;
      wg_s1 <= '0;
      wg_s2 <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (rd_fire) begin
        rbin  <= rbin_nx;
        rgray <= rbin_nx ^ (rbin_nx >> 1);
      end
    end
  end

  // R5
  wr_hold_while_loading_chk: assert property (@(posedge wclk) disable iff (rst)
    !load_n |=> $stable(wbin));
  // R5
  rd_hold_while_loading_chk: assert property (@(posedge rclk) disable iff (rst)
    !load_n |=> $stable(rbin));
  // R5
  fill_bound_chk: assert property (@(posedge wclk) disable iff (rst)
    count_w <= FULL_CNT);

endmodule

// File: rtl/paf_offsets.sv
`timescale 1ns/1ps
module paf_offsets #(
  parameter int DEPTH = 16,
  localparam int OW  = $clog2(DEPTH),
  localparam int BCW = $clog2(2 * OW)
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst,
  input  logic          load_n,
  input  logic [1:0]    fsel,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [OW-1:0] off_in,
  output logic [OW-1:0] ae_off,
  output logic [OW-1:0] af_off,
  output logic [OW-1:0] off_out
);

  localparam logic [BCW-1:0] LAST_BIT = BCW'(2 * OW - 1);

  logic [2*OW-1:0] offs;     // {full offset, empty offset}
  logic            par_mode;
  logic            wsel;
  logic [BCW-1:0]  bitcnt;
  logic            rsel;
  logic [OW-1:0]   dflt;

  always_comb begin
    dflt   = OW'(paf_pkg::dflt_offset({29'd0, load_n, fsel}, DEPTH));
    ae_off = offs[OW-1:0];
    af_off = offs[2*OW-1:OW];
  end

  always_ff @(posedge wclk) begin
    if (rst) begin
      offs     <= {dflt, dflt};
      par_mode <= load_n;
      wsel     <= 1'b0;
      bitcnt   <= '0;
    end else if (load_n) begin
      wsel   <= 1'b0;
      bitcnt <= '0;
    end else if (wr_en) begin
      if (par_mode) begin
        if (wsel) offs[2*OW-1:OW] <= off_in;
        else      offs[OW-1:0]    <= off_in;
        wsel <= ~wsel;
      end else begin
        offs[bitcnt] <= off_in[0];
        bitcnt       <= (bitcnt == LAST_BIT) ? '0 : bitcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge rclk) begin
    if (rst) begin
      rsel    <= 1'b0;
      off_out <= '0;
    end else if (load_n) begin
      rsel <= 1'b0;
    end else if (rd_en) begin
      off_out <= rsel ? af_off : ae_off;
      rsel    <= ~rsel;
    end
  end

  // R6
  offsets_hold_chk: assert property (@(posedge wclk) disable iff (rst)
    !wr_en |=> $stable(offs));
  // R8
  readback_hold_chk: assert property (@(posedge rclk) disable iff (rst)
    !rd_en |=> $stable(off_out));

endmodule

// File: rtl/paf_flags.sv
`timescale 1ns/1ps
module paf_flags #(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH) + 1,
  localparam int OW = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst,
  input  logic          sync_mode,
  input  logic          wr_fire,
  input  logic          rd_fire,
  input  logic [PW-1:0] count_w,
  input  logic [PW-1:0] count_r,
  input  logic [OW-1:0] ae_off,
  input  logic [OW-1:0] af_off,
  output logic          almost_empty_n,
  output logic          almost_full_n
);

  localparam logic [PW-1:0] DEP = PW'(DEPTH);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic mode_w, mode_r;
  logic ae_act_s, af_act_s;        // synchronous-timing flag registers
  logic ae_s, ae_c, af_s, af_c;    // asynchronous set/clear toggles
  logic ae_act_a, af_act_a;
  logic [PW-1:0] free_w, free_r, aeo, afo;

  always_comb begin
    free_w   = DEP - count_w;
    free_r   = DEP - count_r;
    aeo      = PW'(ae_off);
    afo      = PW'(af_off);
    ae_act_a = ~(ae_s ^ ae_c);
    af_act_a = af_s ^ af_c;
    almost_empty_n = ~(mode_r ? ae_act_s : ae_act_a);
    almost_full_n  = ~(mode_w ? af_act_s : af_act_a);
  end

  always_ff @(posedge rclk) begin
    if (rst) begin
      mode_r   <= sync_mode;
      ae_act_s <= 1'b1;
      ae_s     <= 1'b0;
      af_c     <= 1'b0;
    end else begin
      ae_act_s <= (count_r <= aeo);
      if (!mode_r && rd_fire && !ae_act_a && ((count_r - ONE) <= aeo))
        ae_s <= ~ae_s;
      if (!mode_r && rd_fire && af_act_a && ((free_r + ONE) > afo))
        af_c <= ~af_c;
    end
  end

  always_ff @(posedge wclk) begin
    if (rst) begin
      mode_w   <= sync_mode;
      af_act_s <= 1'b0;
      af_s     <= 1'b0;
      ae_c     <= 1'b0;
    end else begin
      af_act_s <= (free_w <= afo);
      if (!mode_w && wr_fire && !af_act_a && ((free_w - ONE) <= afo))
        af_s <= ~af_s;
      if (!mode_w && wr_fire && ae_act_a && ((count_w + ONE) > aeo))
        ae_c <= ~ae_c;
    end
  end

  // R10
  ae_set_on_read_only_chk: assert property (@(posedge rclk) disable iff (rst)
    !rd_fire |=> $stable(ae_s));
  // R10
  af_set_on_write_only_chk: assert property (@(posedge wclk) disable iff (rst)
    !wr_fire |=> $stable(af_s));
  // R9
  sync_toggles_idle_chk: assert property (@(posedge wclk) disable iff (rst)
    mode_w |=> $stable(ae_c) && $stable(af_s));

endmodule

// File: rtl/prog_almost_flags.sv
`timescale 1ns/1ps
module prog_almost_flags #(
  parameter int DEPTH = 16,
  localparam int OW = $clog2(DEPTH),
  localparam int PW = $clog2(DEPTH) + 1
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          load_n,
  input  logic [1:0]    fsel,
  input  logic          sync_mode,
  input  logic [OW-1:0] off_in,
  output logic          almost_empty_n,
  output logic          almost_full_n,
  output logic [OW-1:0] off_out
);

  logic          wr_fire, rd_fire;
  logic [PW-1:0] count_w, count_r;
  logic [OW-1:0] ae_off, af_off;

  paf_level #(.DEPTH(DEPTH)) u_level (
    .wclk(wclk), .rclk(rclk), .rst(rst),
    .wr_en(wr_en), .rd_en(rd_en), .load_n(load_n),
    .wr_fire(wr_fire), .rd_fire(rd_fire),
    .count_w(count_w), .count_r(count_r)
  );

  paf_offsets #(.DEPTH(DEPTH)) u_offsets (
    .wclk(wclk), .rclk(rclk), .rst(rst),
    .load_n(load_n), .fsel(fsel),
    .wr_en(wr_en), .rd_en(rd_en), .off_in(off_in),
    .ae_off(ae_off), .af_off(af_off), .off_out(off_out)
  );

  paf_flags #(.DEPTH(DEPTH)) u_flags (
    .wclk(wclk), .rclk(rclk), .rst(rst), .sync_mode(sync_mode),
    .wr_fire(wr_fire), .rd_fire(rd_fire),
    .count_w(count_w), .count_r(count_r),
    .ae_off(ae_off), .af_off(af_off),
    .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n)
  );

endmodule

// File: tb/prog_almost_flags_test.sv
`timescale 1ns/1ps
module prog_almost_flags_test;

  localparam int D  = 16;
  localparam int OW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic          rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0, load_n = 1'b1, sync_mode = 1'b1;
  logic [1:0]    fsel = 2'b00;
  logic [OW-1:0] off_in = '0;
  logic          almost_empty_n, almost_full_n;
  logic [OW-1:0] off_out;

  prog_almost_flags #(.DEPTH(D)) uut (
    .wclk(clk), .rclk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .load_n(load_n), .fsel(fsel), .sync_mode(sync_mode), .off_in(off_in),
    .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n), .off_out(off_out)
  );

  int checks = 0, fails = 0;
  int cnt = 0, aeo = 0, afo = 0;
  bit done = 0;

  function automatic int dflt(input int idx);
    int v;
    v = 2 * idx + 1;
    return (v > D - 1) ? D - 1 : v;
  endfunction

  function automatic int exp_ae_n();
    return (cnt <= aeo) ? 0 : 1;
  endfunction

  function automatic int exp_af_n();
    return ((D - cnt) <= afo) ? 0 : 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic do_reset(input logic ld, input logic [1:0] fs, input logic sm);
    @(negedge clk);
    rst = 1'b1; load_n = ld; fsel = fs; sync_mode = sm; wr_en = 0; rd_en = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0; load_n = 1'b1;
    cnt = 0;
    aeo = dflt({29'd0, ld, fs});
    afo = aeo;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic check_flags(input string req);
    settle();
    chk({req, " almost_empty_n"}, int'(almost_empty_n), exp_ae_n());
    chk({req, " almost_full_n"}, int'(almost_full_n), exp_af_n());
  endtask

  task automatic wr_pulse();
    @(negedge clk) wr_en = 1'b1;
    @(negedge clk) wr_en = 1'b0;
    if (cnt < D) cnt++;
  endtask

  task automatic rd_pulse();
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    if (cnt > 0) cnt--;
  endtask

  task automatic prog_par(input int e, input int f);
    @(negedge clk) begin load_n = 1'b0; wr_en = 1'b1; off_in = OW'(e); end
    @(negedge clk) off_in = OW'(f);
    @(negedge clk) begin wr_en = 1'b0; load_n = 1'b1; end
    aeo = e; afo = f;
  endtask

  task automatic prog_ser(input int e, input int f);
    logic [2*OW-1:0] v;
    v = {OW'(f), OW'(e)};
    @(negedge clk) begin load_n = 1'b0; wr_en = 1'b1; end
    for (int i = 0; i < 2 * OW; i++) begin
      off_in = OW'($urandom);
      off_in[0] = v[i];
      @(negedge clk);
    end
    wr_en = 1'b0; load_n = 1'b1;
    aeo = e; afo = f;
  endtask

  task automatic readback(input string req);
    @(negedge clk) begin load_n = 1'b0; rd_en = 1'b1; end
    @(negedge clk) chk({req, " empty offset"}, int'(off_out), aeo);
    @(negedge clk) chk({req, " full offset"}, int'(off_out), afo);
    rd_en = 1'b0; load_n = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end

  initial begin
    void'($urandom(32'd7));

    // Synchronous timing, parallel method, index {1,0,1} -> 11
    do_reset(1'b1, 2'b01, 1'b1);
    chk("R2 reset almost_empty_n", int'(almost_empty_n), 0);
    chk("R2 reset almost_full_n", int'(almost_full_n), 1);
    chk("R2 reset off_out", int'(off_out), 0);
    readback("R1 R8 defaults");
    check_flags("R5 readback does not move the count");

    for (int i = 0; i < 11; i++) wr_pulse();
    check_flags("R3 count at empty offset");
    wr_pulse();
    chk("R9 sync release delayed", int'(almost_empty_n), 0);
    check_flags("R9 R3 released after settle");
    rd_pulse();
    chk("R9 sync assert delayed", int'(almost_empty_n), 1);
    check_flags("R9 R3 asserted after settle");

    while (cnt < D) begin wr_pulse(); check_flags("R4 filling"); end
    wr_pulse();
    check_flags("R5 write at full ignored");
    while (cnt > 0) begin rd_pulse(); check_flags("R3 R4 draining"); end
    rd_pulse();
    check_flags("R5 read at empty ignored");
    wr_pulse();
    check_flags("R5 count after empty read");

    // R6: three parallel strobes wrap back to the empty offset
    @(negedge clk) begin load_n = 1'b0; wr_en = 1'b1; off_in = 4'd3; end
    @(negedge clk) off_in = 4'd5;
    @(negedge clk) off_in = 4'd2;
    @(negedge clk) begin wr_en = 1'b0; load_n = 1'b1; end
    aeo = 2; afo = 5;
    readback("R6 R8 parallel wrap");
    check_flags("R6 R3 flags with new offsets");
    prog_par(0, 1);
    readback("R6 restart after load high");
    check_flags("R4 R5 offset writes leave count");

    // Asynchronous timing, serial method, index {0,1,1} -> 7
    do_reset(1'b0, 2'b11, 1'b0);
    chk("R2 async reset almost_empty_n", int'(almost_empty_n), 0);
    chk("R2 async reset almost_full_n", int'(almost_full_n), 1);
    readback("R1 R8 async defaults");
    for (int i = 0; i < 7; i++) wr_pulse();
    check_flags("R3 async at offset");
    wr_pulse();
    chk("R10 ae released at write edge", int'(almost_empty_n), 1);
    settle();
    rd_pulse();
    chk("R10 ae asserted at read edge", int'(almost_empty_n), 0);
    settle();
    wr_pulse(); settle();
    wr_pulse();
    chk("R10 af asserted at write edge", int'(almost_full_n), 0);
    settle();
    rd_pulse();
    chk("R10 af released at read edge", int'(almost_full_n), 1);
    settle();
    prog_ser(2, 13);
    readback("R7 R8 serial load");
    prog_ser(9, 4);
    readback("R7 serial reload");

    // Randomised phase, synchronous timing, index {1,0,0} -> 9
    do_reset(1'b1, 2'b00, 1'b1);
    readback("R1 default index 4");
    for (int n = 0; n < 250; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 5)      wr_pulse();
      else if (r < 9) rd_pulse();
      else begin
        prog_par($urandom_range(0, D - 1), $urandom_range(0, D - 1));
        readback("R6 R8 random offsets");
      end
      check_flags("R3 R4 random");
    end

    done = 1;
    summary();
  end

endmodule